// File: doc/BRIEF.md
# Serial Read Transmitter with Appended CRC-8

This block sends a stream of read-data bytes out on a single serial line, one bit per bit-time strobe, least significant bit first. A start pulse opens a transaction and the 2-bit opcode is captured at that moment. Bytes come in over a valid/ready handshake. A last flag marks the final byte of the transaction.

When the captured opcode selects checked reads, an 8-bit CRC runs alongside the output. Every bit that leaves the line is folded into the CRC register on the same strobe that sends it. After the last data byte, the register contents go out as one extra byte, also LSB first. For any other opcode only the data bytes are sent. A one-cycle done pulse follows the final bit, and the block then waits idle for the next start.

Top module: `rd_crc_serializer`

## Requirements
- R1: After reset the block is idle: `sdo_o` is 1, and `sdo_valid_o`, `byte_ready_o` and `done_o` are 0.
- R2: A `start_i` pulse while idle begins a transaction and samples `opcode_i` at that moment. A `start_i` pulse during a transaction has no effect on it, and neither does a change of `opcode_i` during a transaction.
- R3: The CRC uses the polynomial x^8 + x^5 + x^4 + 1 in reflected form. For each bit sent, feedback = crc[0] XOR bit, the register shifts right, and it is XORed with 8'h8C when feedback is 1. The register is cleared to zero at the start of every transaction.
- R4: When the sampled opcode is 2'b10, one CRC byte, computed over all data bits of the transaction, is sent directly after the last data byte. For opcodes 2'b00, 2'b01 and 2'b11 no extra byte is sent.
- R5: Every data byte and the CRC byte are sent least significant bit first, eight bits each.
- R6: `sdo_valid_o` is high while a bit is on the line. The bit is sent on a clock where `bit_tick_i` is high. Without a strobe, `sdo_o` and `sdo_valid_o` hold their values.
- R7: `byte_ready_o` is high only while the block waits for the next data byte, and never together with `sdo_valid_o`. A byte is taken when `byte_valid_i` and `byte_ready_o` are both high. The `byte_last_i` flag taken with it marks the final data byte.
- R8: `done_o` is high for exactly one clock after the final bit is sent: the CRC MSB in CRC mode, or the last data MSB otherwise. The block is idle in that cycle and stays idle until the next start.
- R9: In CRC mode the data bits followed by the CRC byte, run through the same CRC, leave a residue of zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Transaction start pulse |
| opcode_i | input | 2 | Read opcode; 2'b10 selects CRC append |
| byte_i | input | 8 | Read data byte |
| byte_valid_i | input | 1 | Data byte valid |
| byte_last_i | input | 1 | Byte is the last of the transaction |
| byte_ready_o | output | 1 | Block can take a data byte |
| bit_tick_i | input | 1 | Bit-time strobe, one bit sent per strobe |
| sdo_o | output | 1 | Serial data out, 1 when idle |
| sdo_valid_o | output | 1 | A bit is being driven on `sdo_o` |
| done_o | output | 1 | One-cycle pulse after the final bit |

## Verification
Several properties are checked on every clock by assertions:
- the line holds between strobes;
- ready never coincides with a bit in flight;
- done lasts one cycle and leaves the block idle;
- the CRC register reads zero at done in CRC mode.

Only the bench scenarios can show the rest, because it depends on the whole bit sequence. This covers the exact bit order, the appended CRC value, its absence for the other three opcodes, and the fact that a start or opcode change in mid-transaction alters nothing. The bench therefore compares the full captured bit stream against a reference built from the requirements. It does so under random strobe spacing and random byte gaps, and with directed corner cases (single byte, all-zero data, strobe on every clock).

// File: rtl/rd_crc_serializer.sv
module rd_crc_serializer #(
  parameter int              W          = 8,
  parameter logic [W-1:0]    CRC_POLY_R = 8'h8C,
  parameter logic [1:0]      CRC_OPCODE = 2'b10
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         start_i,
  input  logic [1:0]   opcode_i,
  input  logic [W-1:0] byte_i,
  input  logic         byte_valid_i,
  input  logic         byte_last_i,
  output logic         byte_ready_o,
  input  logic         bit_tick_i,
  output logic         sdo_o,
  output logic         sdo_valid_o,
  output logic         done_o
);
  localparam int CNT_W = $clog2(W);
  localparam logic [CNT_W-1:0] CNT_TOP = CNT_W'(W - 1);

  typedef enum logic [1:0] {S_IDLE, S_LOAD, S_SEND} st_t;

  st_t              st;
  logic [W-1:0]     sh;
  logic [W-1:0]     crc;
  logic [CNT_W-1:0] cnt;
  logic             crc_en, last_q, in_crc, done_q;

  wire              fb     = crc[0] ^ sh[0];
  wire [W-1:0]      crc_nx = (crc >> 1) ^ (fb ? CRC_POLY_R : '0);
  wire              tick   = (st == S_SEND) && bit_tick_i;

  assign byte_ready_o = (st == S_LOAD);
  assign sdo_valid_o  = (st == S_SEND);
  assign sdo_o        = sdo_valid_o ? sh[0] : 1'b1;
  assign done_o       = done_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st     <= S_IDLE;
      sh     <= '0;
      crc    <= '0;
      cnt    <= '0;
      crc_en <= 1'b0;
      last_q <= 1'b0;
      in_crc <= 1'b0;
      done_q <= 1'b0;
    end else begin
      done_q <= 1'b0;
      case (st)
        S_IDLE: if (start_i) begin
          crc    <= '0;
          crc_en <= (opcode_i == CRC_OPCODE);
          in_crc <= 1'b0;
          st     <= S_LOAD;
        end
        S_LOAD: if (byte_valid_i) begin
          sh     <= byte_i;
          last_q <= byte_last_i;
          cnt    <= '0;
          st     <= S_SEND;
        end
        S_SEND: if (tick) begin
          crc <= crc_nx;
          sh  <= sh >> 1;
          cnt <= cnt + 1'b1;
          if (cnt == CNT_TOP) begin
            if (!last_q) begin
              st <= S_LOAD;
            end else if (crc_en && !in_crc) begin
              sh     <= crc_nx;
              in_crc <= 1'b1;
              cnt    <= '0;
            end else begin
              st     <= S_IDLE;
              done_q <= 1'b1;
            end
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  // R6
  line_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sdo_valid_o && !bit_tick_i) |=> (sdo_valid_o && $stable(sdo_o)));

  // R7
  ready_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(byte_ready_o && sdo_valid_o));

  // R8
  done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);

  // R8
  done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> (!sdo_valid_o && !byte_ready_o && sdo_o));

  // R9
  crc_residue_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done_o && crc_en) |-> (crc == '0));

  // R4
  crc_byte_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_crc |-> crc_en);
endmodule

// File: tb/rd_crc_serializer_tb.sv
module rd_crc_serializer_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       start_i = 1'b0;
  logic [1:0] opcode_i = 2'b00;
  logic [7:0] byte_i = 8'h00;
  logic       byte_valid_i = 1'b0;
  logic       byte_last_i = 1'b0;
  logic       bit_tick_i = 1'b0;
  logic       byte_ready_o, sdo_o, sdo_valid_o, done_o;

  int errors = 0;
  int checks = 0;

  logic [7:0] data [16];
  bit         got  [0:511];
  bit         expb [0:511];
  int         ngot, nexp;

  always #5 clk = ~clk;

  rd_crc_serializer u_dut (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .opcode_i(opcode_i),
    .byte_i(byte_i), .byte_valid_i(byte_valid_i), .byte_last_i(byte_last_i),
    .byte_ready_o(byte_ready_o), .bit_tick_i(bit_tick_i), .sdo_o(sdo_o),
    .sdo_valid_o(sdo_valid_o), .done_o(done_o)
  );

  function automatic logic [7:0] crc_bit(logic [7:0] c, logic b);
    logic f;
    f = c[0] ^ b;
    c = c >> 1;
    if (f) c = c ^ 8'h8C;
    return c;
  endfunction

  function automatic logic [7:0] crc_bytes(int n);
    logic [7:0] c = 8'h00;
    for (int i = 0; i < n; i++)
      for (int k = 0; k < 8; k++) c = crc_bit(c, data[i][k]);
    return c;
  endfunction

  task automatic chk(bit ok, string req, string what, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // op: opcode; n: byte count; fast: strobe every clock; mid: disturb mid-transaction
  task automatic run_txn(logic [1:0] op, int n, bit fast, bit mid);
    int  idx = 0;
    int  cyc = 0;
    bit  seen_done = 0;
    logic [7:0] c;
    nexp = 0;
    for (int i = 0; i < n; i++)
      for (int k = 0; k < 8; k++) expb[nexp++] = data[i][k];
    if (op == 2'b10) begin
      c = crc_bytes(n);
      for (int k = 0; k < 8; k++) expb[nexp++] = c[k];
    end
    ngot = 0;
    @(negedge clk);
    start_i  = 1'b1;
    opcode_i = op;
    @(negedge clk);
    start_i  = 1'b0;
    while (!seen_done && cyc < 20000) begin
      bit_tick_i   = fast ? 1'b1 : (($urandom % 3) == 0);
      byte_valid_i = (idx < n) && (($urandom % 4) != 0);
      byte_i       = (idx < n) ? data[idx] : 8'hxx;
      byte_last_i  = (idx == n - 1);
      if (mid && ngot == 3) begin
        start_i  = 1'b1;
        opcode_i = (op == 2'b10) ? 2'b01 : 2'b10;
      end else begin
        start_i  = 1'b0;
      end
      #4;
      if (byte_valid_i && byte_ready_o) idx++;
      if (bit_tick_i && sdo_valid_o && ngot < 512) got[ngot++] = sdo_o;
      if (done_o) seen_done = 1;
      @(negedge clk);
      cyc++;
    end
    start_i = 1'b0; bit_tick_i = 1'b0; byte_valid_i = 1'b0; byte_last_i = 1'b0;
    chk(seen_done, "R8", "done pulse seen", seen_done, 1);
    chk(ngot == nexp, "R4", "bit count", ngot, nexp);
    begin
      int bad = -1;
      for (int i = 0; i < nexp && i < ngot; i++)
        if (bad < 0 && got[i] != expb[i]) bad = i;
      chk(bad < 0, mid ? "R2" : "R5", "first mismatching bit index", bad, -1);
    end
    if (op == 2'b10 && ngot == nexp) begin
      logic [7:0] r = 8'h00;
      logic [7:0] cb = 8'h00;
      for (int i = 0; i < ngot; i++) r = crc_bit(r, got[i]);
      for (int k = 0; k < 8; k++) cb[k] = got[ngot - 8 + k];
      chk(cb == crc_bytes(n), "R3", "appended CRC byte", cb, crc_bytes(n));
      chk(r == 8'h00, "R9", "residue over data+CRC", r, 0);
    end
    #4;
    chk(!done_o && !sdo_valid_o && !byte_ready_o && sdo_o, "R8",
        "idle after done", {done_o, sdo_valid_o, byte_ready_o, sdo_o}, 4'b0001);
    repeat (3) @(negedge clk);
    #4;
    chk(!sdo_valid_o && !byte_ready_o, "R8", "stays idle",
        {sdo_valid_o, byte_ready_o}, 0);
  endtask

  initial begin
    void'($urandom(32'd1234));
    repeat (2) @(negedge clk);
    #4;
    chk(sdo_o && !sdo_valid_o && !byte_ready_o && !done_o, "R1", "reset state",
        {sdo_o, sdo_valid_o, byte_ready_o, done_o}, 4'b1000);
    rst_n = 1'b1;
    @(negedge clk);
    #4;
    chk(!byte_ready_o && !sdo_valid_o, "R2", "no start keeps idle",
        {byte_ready_o, sdo_valid_o}, 0);

    // R3 reference sanity: classic 7-byte vector yields 8'hA2
    data[0]=8'h02; data[1]=8'h1C; data[2]=8'hB8; data[3]=8'h01;
    data[4]=8'h00; data[5]=8'h00; data[6]=8'h00;
    chk(crc_bytes(7) == 8'hA2, "R3", "model vector", crc_bytes(7), 8'hA2);
    run_txn(2'b10, 7, 1'b0, 1'b0);

    // R4 single byte, CRC mode, strobe every clock
    data[0] = 8'h5A;
    run_txn(2'b10, 1, 1'b1, 1'b0);
    // R3 all-zero data gives zero CRC
    data[0] = 8'h00; data[1] = 8'h00;
    run_txn(2'b10, 2, 1'b1, 1'b0);
    // R4 no CRC for other opcodes
    data[0] = 8'hC3; data[1] = 8'h81;
    run_txn(2'b00, 2, 1'b0, 1'b0);
    run_txn(2'b01, 2, 1'b1, 1'b0);
    run_txn(2'b11, 1, 1'b0, 1'b0);
    // R2 start and opcode changes mid-transaction are ignored
    data[0] = 8'h3E; data[1] = 8'h77; data[2] = 8'h10;
    run_txn(2'b00, 3, 1'b0, 1'b1);
    run_txn(2'b10, 3, 1'b0, 1'b1);
    // R6 R7 random mix
    for (int t = 0; t < 24; t++) begin
      int n = 1 + ($urandom % 16);
      for (int i = 0; i < n; i++) data[i] = 8'($urandom);
      run_txn(2'($urandom), n, ($urandom % 4) == 0, 1'b0);
    end
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule